// File: doc/BRIEF.md
# Trigger Bus Pattern Matcher

This block holds a 48-bit trigger word that describes one candidate event. The word carries veto flags, stopping-layer flags, beam and target timing conditions and a topology-valid flag. The block tests the word against up to sixteen programmable trigger definitions at the same time. Each definition has an enable bit and two 48-bit masks. The first mask lists bits that must be one. The second lists bits that must be zero.

While no definition matches, every new candidate word that arrives over the valid/ready input replaces the held word. When the held word satisfies at least one enabled definition, the block freezes. It raises a fixed-length interim inhibit pulse and registers a 16-bit vector that shows which definitions matched. During the last cycle of that pulse the downstream sequencer makes a choice through `extend_inhibit`. If it is low, the freeze lapses when the pulse ends. If it is high, the word and the vector stay held until the sequencer pulses `release_freeze`.

Back-pressure rules for the input stream:
- A word is transferred only in a cycle where both `bus_valid` and `bus_ready` are high.
- `bus_ready` is low while the block is frozen. It is also low in the cycle where the held word already matches, so a matching word cannot be overwritten before the freeze takes hold.
- Candidate words go stale, so a source may withdraw `bus_valid` without a transfer.

Top module: `trig_bus_matcher`

## Requirements
- R1: After reset, `frozen`, `inhibit` and `match_vec` are zero, `bus_ready` is one, and every definition is disabled.
- R2: While the block is not frozen and the held word matches nothing, each transferred word appears on `held_bus` in the cycle after the transfer edge, and the block stays unfrozen.
- R3: Definition i matches when three conditions hold: it is enabled, every bit set in its must-one mask is one in the held word, and every bit set in its must-zero mask is zero in the held word. A single offending bit prevents the match.
- R4: One clock edge after a matching word is transferred, `frozen` and `inhibit` rise together. `inhibit` then stays high for exactly INH_CYCLES cycles.
- R5: `match_vec` bit i is set when definition i matched. The vector is registered when the freeze begins, stays stable for the whole freeze, and reads zero whenever the block is not frozen.
- R6: `bus_ready` is low while the block is frozen, and also in the cycle where the held word matches. During that time `held_bus` does not change, whatever `bus_valid` and `bus_data` do.
- R7: If `extend_inhibit` is low in the last inhibit cycle, `frozen` falls on the same edge as `inhibit`.
- R8: If `extend_inhibit` is high in the last inhibit cycle, the freeze continues after `inhibit` falls and ends one edge after a cycle where `release_freeze` is high. A `release_freeze` pulse during the interim inhibit has no effect.
- R9: A disabled definition never matches. An enabled definition whose masks are both zero matches any word.
- R10: When several definitions match the same word, all of their bits are set in `match_vec` together.
- R11: After a freeze ends, `bus_ready` returns high, and the old held word does not start a new freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Candidate word offered |
| bus_ready | output | 1 | Block can accept a word |
| bus_data | input | 48 | Candidate trigger word |
| cfg_we | input | 1 | Write one definition |
| cfg_idx | input | 4 | Definition number to write |
| cfg_en | input | 1 | Enable bit for the written definition |
| cfg_ones | input | 48 | Must-be-one mask |
| cfg_zeros | input | 48 | Must-be-zero mask |
| extend_inhibit | input | 1 | Keep the freeze after the interim pulse |
| release_freeze | input | 1 | Pulse that ends an extended freeze |
| held_bus | output | 48 | Currently held trigger word |
| frozen | output | 1 | Word and match vector are frozen |
| inhibit | output | 1 | Interim inhibit pulse |
| match_vec | output | 16 | Matched definitions, one bit each |

## Verification
Some properties are checked on every cycle by the assertions. These are the relations between the outputs: inhibit implies frozen, frozen implies no ready, the held word and the vector stay stable through a freeze, the vector is zero outside a freeze, and the inhibit pulse has exactly the right length. They also check that a freeze begins with a non-empty vector, that it drops with the pulse when it was not extended, and that a held freeze waits for release. Other behaviour can only be shown by the bench's scenarios. That covers whether a given word really matches a given pair of masks, the single-bit rejections, the disabled and empty-mask definitions, the report of several matches at once, and the absence of a retrigger from the stale word after release.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;
  typedef enum logic [1:0] {
    FRZ_IDLE    = 2'd0,
    FRZ_INTERIM = 2'd1,
    FRZ_HELD    = 2'd2
  } frz_state_e;
endpackage

// File: rtl/trig_def_bank.sv
module trig_def_bank #(
  parameter int BUS_W = 48,
  parameter int N_DEF = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic [BUS_W-1:0] cfg_ones,
  input  logic [BUS_W-1:0] cfg_zeros,
  input  logic [BUS_W-1:0] word,
  input  logic             word_vld,
  output logic [N_DEF-1:0] hits
);
  for (genvar g = 0; g < N_DEF; g++) begin : g_def
    logic             en_q;
    logic [BUS_W-1:0] ones_q;
    logic [BUS_W-1:0] zeros_q;
    logic             sel;

    assign sel = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q    <= 1'b0;
        ones_q  <= '0;
        zeros_q <= '0;
      end else if (sel) begin
        en_q    <= cfg_en;
        ones_q  <= cfg_ones;
        zeros_q <= cfg_zeros;
      end
    end

    // all required ones present, no forbidden bit present
    assign hits[g] = word_vld && en_q &&
                     ((word & ones_q) == ones_q) &&
                     ((word & zeros_q) == '0);
  end
endmodule

// File: rtl/trig_bus_latch.sv
module trig_bus_latch #(
  parameter int BUS_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [BUS_W-1:0] data_in,
  input  logic             drop_vld,
  output logic [BUS_W-1:0] word_q,
  output logic             word_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_vld <= 1'b0;
    end else if (drop_vld) begin
      word_vld <= 1'b0;
    end else if (accept) begin
      word_q   <= data_in;
      word_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_freeze_ctrl.sv
module trig_freeze_ctrl
  import trig_match_pkg::*;
#(
  parameter int N_DEF      = 16,
  parameter int INH_CYCLES = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEF-1:0] hits,
  input  logic             extend,
  input  logic             release_i,
  output logic             frozen,
  output logic             inhibit,
  output logic [N_DEF-1:0] match_q,
  output logic             end_freeze
);
  localparam int CNT_W = $clog2(INH_CYCLES + 1);

  frz_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [N_DEF-1:0] match_d;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    match_d    = match_q;
    end_freeze = 1'b0;
    unique case (st_q)
      FRZ_IDLE: begin
        if (|hits) begin
          st_d    = FRZ_INTERIM;
          cnt_d   = CNT_W'(INH_CYCLES);
          match_d = hits;
        end
      end
      FRZ_INTERIM: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          if (extend) begin
            st_d = FRZ_HELD;
          end else begin
            st_d       = FRZ_IDLE;
            match_d    = '0;
            end_freeze = 1'b1;
          end
        end
      end
      FRZ_HELD: begin
        if (release_i) begin
          st_d       = FRZ_IDLE;
          match_d    = '0;
          end_freeze = 1'b1;
        end
      end
      default: begin
        st_d    = FRZ_IDLE;
        match_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FRZ_IDLE;
      cnt_q   <= '0;
      match_q <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      match_q <= match_d;
    end
  end

  assign frozen  = (st_q != FRZ_IDLE);
  assign inhibit = (st_q == FRZ_INTERIM);
endmodule

// File: rtl/trig_bus_matcher.sv
module trig_bus_matcher #(
  parameter int BUS_W      = 48,
  parameter int N_DEF      = 16,
  parameter int INH_CYCLES = 13,
  localparam int IDX_W     = (N_DEF > 1) ? $clog2(N_DEF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  output logic             bus_ready,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic [BUS_W-1:0] cfg_ones,
  input  logic [BUS_W-1:0] cfg_zeros,
  input  logic             extend_inhibit,
  input  logic             release_freeze,
  output logic [BUS_W-1:0] held_bus,
  output logic             frozen,
  output logic             inhibit,
  output logic [N_DEF-1:0] match_vec
);
  logic [N_DEF-1:0] hits;
  logic             word_vld;
  logic             accept;
  logic             end_freeze;

  assign bus_ready = !frozen && !(|hits);
  assign accept    = bus_valid && bus_ready;

  trig_bus_latch #(.BUS_W(BUS_W)) latch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .data_in  (bus_data),
    .drop_vld (end_freeze),
    .word_q   (held_bus),
    .word_vld (word_vld)
  );

  trig_def_bank #(.BUS_W(BUS_W), .N_DEF(N_DEF), .IDX_W(IDX_W)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_en    (cfg_en),
    .cfg_ones  (cfg_ones),
    .cfg_zeros (cfg_zeros),
    .word      (held_bus),
    .word_vld  (word_vld),
    .hits      (hits)
  );

  trig_freeze_ctrl #(.N_DEF(N_DEF), .INH_CYCLES(INH_CYCLES)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hits       (hits),
    .extend     (extend_inhibit),
    .release_i  (release_freeze),
    .frozen     (frozen),
    .inhibit    (inhibit),
    .match_q    (match_vec),
    .end_freeze (end_freeze)
  );
endmodule

// File: rtl/trig_bus_matcher_chk.sv
module trig_bus_matcher_chk #(
  parameter int BUS_W      = 48,
  parameter int N_DEF      = 16,
  parameter int INH_CYCLES = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_ready,
  input logic [BUS_W-1:0] held_bus,
  input logic             frozen,
  input logic             inhibit,
  input logic [N_DEF-1:0] match_vec,
  input logic             extend_inhibit,
  input logic             release_freeze
);
  localparam int RUN_W = $clog2(INH_CYCLES + 2) + 1;
  logic [RUN_W-1:0] inh_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inh_run <= '0;
    else if (inhibit) inh_run <= inh_run + 1'b1;
    else inh_run <= '0;
  end

  // R4
  inhibit_in_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> frozen);

  // R4
  inhibit_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (inh_run < RUN_W'(INH_CYCLES)));

  // R4
  inhibit_not_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit && (inh_run != '0)) |-> (inh_run == RUN_W'(INH_CYCLES)));

  // R5
  freeze_starts_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> (inhibit && (match_vec != '0)));

  // R5
  vec_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen |-> (match_vec == '0));

  // R5
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(match_vec));

  // R6
  no_ready_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !bus_ready);

  // R6
  bus_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(held_bus));

  // R7
  lapse_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(inhibit) && !$past(extend_inhibit)) |-> !frozen);

  // R8
  held_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !inhibit && !release_freeze) |=> frozen);
endmodule

bind trig_bus_matcher trig_bus_matcher_chk #(
  .BUS_W(BUS_W), .N_DEF(N_DEF), .INH_CYCLES(INH_CYCLES)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_ready      (bus_ready),
  .held_bus       (held_bus),
  .frozen         (frozen),
  .inhibit        (inhibit),
  .match_vec      (match_vec),
  .extend_inhibit (extend_inhibit),
  .release_freeze (release_freeze)
);

// File: tb/trig_bus_matcher_tb_top.sv
module trig_bus_matcher_tb_top;
  localparam int BUS_W = 48;
  localparam int N_DEF = 16;
  localparam int INH   = 13;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_valid = 1'b0;
  logic             bus_ready;
  logic [BUS_W-1:0] bus_data = '0;
  logic             cfg_we = 1'b0;
  logic [3:0]       cfg_idx = '0;
  logic             cfg_en = 1'b0;
  logic [BUS_W-1:0] cfg_ones = '0;
  logic [BUS_W-1:0] cfg_zeros = '0;
  logic             extend_inhibit = 1'b0;
  logic             release_freeze = 1'b0;
  logic [BUS_W-1:0] held_bus;
  logic             frozen;
  logic             inhibit;
  logic [N_DEF-1:0] match_vec;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trig_bus_matcher #(.BUS_W(BUS_W), .N_DEF(N_DEF), .INH_CYCLES(INH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_data(bus_data), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_ones(cfg_ones), .cfg_zeros(cfg_zeros), .extend_inhibit(extend_inhibit),
    .release_freeze(release_freeze), .held_bus(held_bus), .frozen(frozen),
    .inhibit(inhibit), .match_vec(match_vec)
  );

  // typical definition: coincidence, stop, delayed decay, inner layer;
  // outer layer and photon vetoes must be clear
  localparam logic [BUS_W-1:0] D0_ONES  = (48'd1 << 0) | (48'd1 << 1) | (48'd1 << 2) | (48'd1 << 10);
  localparam logic [BUS_W-1:0] D0_ZEROS = (48'd1 << 19) | (48'h3F << 40);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic program_def(input int idx, input logic en,
                             input logic [BUS_W-1:0] ones, input logic [BUS_W-1:0] zeros);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_en = en; cfg_ones = ones; cfg_zeros = zeros;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // returns at the negedge after the transfer edge
  task automatic send_word(input logic [BUS_W-1:0] w);
    @(negedge clk);
    bus_valid = 1'b1; bus_data = w;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 frozen", 64'(frozen), 64'd0);
    check("R1 inhibit", 64'(inhibit), 64'd0);
    check("R1 match_vec", 64'(match_vec), 64'd0);
    check("R1 ready", 64'(bus_ready), 64'd1);
  endtask

  task automatic t_nomatch(input logic [BUS_W-1:0] w, input string req);
    send_word(w);
    check({req, " held word"}, 64'(held_bus), 64'(w));
    @(negedge clk);
    check({req, " no freeze"}, 64'(frozen), 64'd0);
    check({req, " ready"}, 64'(bus_ready), 64'd1);
  endtask

  task automatic t_match_lapse;
    logic [BUS_W-1:0] w;
    int n;
    w = D0_ONES | (48'd1 << 11);
    send_word(w);
    check("R6 ready low on match", 64'(bus_ready), 64'd0);
    check("R4 not yet frozen", 64'(frozen), 64'd0);
    @(negedge clk);
    check("R4 frozen", 64'(frozen), 64'd1);
    check("R10 vec def0", 64'(match_vec), 64'h1);
    bus_valid = 1'b1; bus_data = 48'hFFFF_0000_AAAA;
    n = 0;
    while (inhibit && n < 100) begin n++; @(negedge clk); end
    bus_valid = 1'b0;
    check("R4 inhibit length", 64'(n), 64'(INH));
    check("R6 held unchanged", 64'(held_bus), 64'(w));
    check("R7 lapse", 64'(frozen), 64'd0);
    check("R5 vec cleared", 64'(match_vec), 64'd0);
    repeat (3) @(negedge clk);
    check("R11 ready back", 64'(bus_ready), 64'd1);
    check("R11 no retrigger", 64'(frozen), 64'd0);
  endtask

  task automatic t_match_hold;
    logic [BUS_W-1:0] w;
    int ok;
    program_def(3, 1'b1, 48'd1 << 20, '0);
    w = D0_ONES | (48'd1 << 20);
    extend_inhibit = 1'b1;
    send_word(w);
    @(negedge clk);
    check("R10 two defs", 64'(match_vec), 64'h9);
    release_freeze = 1'b1;
    @(negedge clk);
    release_freeze = 1'b0;
    check("R8 release ignored in pulse", 64'(frozen), 64'd1);
    while (inhibit) @(negedge clk);
    ok = 1;
    repeat (5) begin
      if (!frozen || match_vec != 16'h9 || held_bus != w) ok = 0;
      @(negedge clk);
    end
    check("R8 held after pulse", 64'(ok), 64'd1);
    extend_inhibit = 1'b0;
    release_freeze = 1'b1;
    @(negedge clk);
    release_freeze = 1'b0;
    check("R8 released", 64'(frozen), 64'd0);
    check("R11 ready after release", 64'(bus_ready), 64'd1);
  endtask

  task automatic t_enable;
    program_def(1, 1'b0, 48'd1 << 30, '0);
    t_nomatch(48'd1 << 30, "R9 disabled");
    program_def(5, 1'b1, '0, '0);
    send_word('0);
    @(negedge clk);
    check("R9 empty masks freeze", 64'(frozen), 64'd1);
    check("R9 empty masks vec", 64'(match_vec), 64'h20);
    while (frozen) @(negedge clk);
    program_def(5, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    program_def(0, 1'b1, D0_ONES, D0_ZEROS);
    t_nomatch(48'h0000_0000_0123, "R2 plain word");
    t_nomatch(D0_ONES | (48'd1 << 42), "R3 veto set");
    t_nomatch(D0_ONES | (48'd1 << 19), "R3 outer layer");
    t_nomatch(D0_ONES & ~(48'd1 << 2), "R3 missing bit");
    t_match_lapse();
    t_match_hold();
    t_enable();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule